// File: doc/BRIEF.md
# Double-to-Unsigned-Word Truncating Converter

This unit turns a 64-bit IEEE-754 binary64 operand into an unsigned 32-bit integer. The fraction is always discarded, so rounding is toward zero. The integer is copied into the two most significant 32-bit words of a 128-bit vector-register-style result, and the two least significant words are zeroed. Status flags for the conversion are produced alongside the result.

The operand is accepted on a valid strobe. The result and flags are registered one clock later, and they hold their values while no new operand arrives.

Fixed range rules set the result for special inputs:
- NaNs and values at or below -1 give zero and raise the invalid flag.
- Values at or above 2^32 give 0xFFFF_FFFF and raise the invalid flag.
- Negative values above -1 give zero and raise the inexact flags.
- The rounded flag never rises.

Top module: `dpuw_conv`

## Requirements
- R1: When `valid_o` is 1, `result_o[127:96]` (word 0) and `result_o[95:64]` (word 1) both carry the converted integer, and `result_o[63:0]` (words 2 and 3) is zero.
- R2: All outputs are registered. `valid_o` is `valid_i` delayed by one clock. While `valid_i` is 0 the result and flags hold. Reset drives every output to 0.
- R3: A NaN source (exponent all ones, mantissa nonzero) of either sign gives result 0 with `invalid_o`=1 and `inexact_o`=0. `snan_o` is 1 exactly when mantissa bit 51 is 0, which marks a signaling NaN.
- R4: A source at or below -1, including -infinity, gives 0 with `invalid_o`=1 and both inexact flags 0.
- R5: A nonzero source strictly between -1 and 0, including negative subnormals, gives 0 with `frac_inexact_o`=1, `inexact_o`=1 and `invalid_o`=0.
- R6: +0 and -0 give 0 with all flags 0.
- R7: A positive non-integer source below 2^32-1 gives its truncated integer with `frac_inexact_o`=1 and `inexact_o`=1.
- R8: A positive integer-valued source up to and including 2^32-1 gives that exact value with all flags 0.
- R9: A source strictly between 2^32-1 and 2^32 gives 0xFFFF_FFFF with both inexact flags 1 and `invalid_o`=0.
- R10: A source at or above 2^32, including +infinity, gives 0xFFFF_FFFF with `invalid_o`=1 and both inexact flags 0.
- R11: `frac_rounded_o` is 0 for every conversion.
- R12: A positive nonzero subnormal source gives 0 with both inexact flags 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operand strobe |
| src_i | input | 64 | binary64 operand |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 128 | Integer in words 0 and 1, words 2 and 3 zero |
| frac_rounded_o | output | 1 | Fraction-rounded flag, always 0 |
| frac_inexact_o | output | 1 | Discarded fraction was nonzero |
| invalid_o | output | 1 | Invalid conversion (NaN or out of range) |
| snan_o | output | 1 | Source was a signaling NaN |
| inexact_o | output | 1 | Inexact exception flag |

## Verification
Every result and flag is due exactly one rising edge after the cycle in which `valid_i` is high. There is a single output register stage and no other pipeline.

The bench drives each operand on a falling edge and samples every output on the following falling edge. This sits half a period after the capturing edge and keeps sampling clear of the edge where the outputs change.

The hold check lowers the strobe, changes the operand, and samples again one full cycle later. The reset check samples before the first strobe.

// File: rtl/dpuw_pkg.sv
package dpuw_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO, CLS_SUB, CLS_NORM, CLS_INF, CLS_QNAN, CLS_SNAN
  } cls_e;

  typedef struct packed {
    logic rounded;
    logic frac_inx;
    logic invalid;
    logic snan;
    logic inexact;
  } flags_t;
endpackage

// File: rtl/dpuw_classify.sv
module dpuw_classify import dpuw_pkg::*; #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] src_i,
  output logic                 sign_o,
  output logic [EXP_W-1:0]     exp_o,
  output logic [MAN_W:0]       sig_o,
  output cls_e                 cls_o
);
  logic [MAN_W-1:0] man;
  logic             exp_max, exp_zero;

  assign sign_o   = src_i[EXP_W+MAN_W];
  assign exp_o    = src_i[EXP_W+MAN_W-1:MAN_W];
  assign man      = src_i[MAN_W-1:0];
  assign exp_max  = &exp_o;
  assign exp_zero = ~|exp_o;
  // hidden bit is 1 only for normals
  assign sig_o    = {~exp_zero, man};

  always_comb begin
    if (exp_max)       cls_o = (man == '0) ? CLS_INF : (man[MAN_W-1] ? CLS_QNAN : CLS_SNAN);
    else if (exp_zero) cls_o = (man == '0) ? CLS_ZERO : CLS_SUB;
    else               cls_o = CLS_NORM;
  end
endmodule

// File: rtl/dpuw_trunc.sv
module dpuw_trunc import dpuw_pkg::*; #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 32
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic [MAN_W:0]   sig_i,
  input  cls_e             cls_i,
  output logic [INT_W-1:0] int_o,
  output logic             lost_o,
  output logic             ge_one_o,
  output logic             big_o
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int ROOF = BIAS + INT_W;

  logic [EXP_W-1:0] sh;
  logic [MAN_W:0]   shifted, keep_mask;
  logic             below_one, above_roof;

  assign below_one  = exp_i < EXP_W'(BIAS);
  assign above_roof = exp_i >= EXP_W'(ROOF);
  assign sh         = EXP_W'(BIAS + MAN_W) - exp_i;
  assign shifted    = sig_i >> sh;
  assign keep_mask  = {(MAN_W+1){1'b1}} << sh;

  always_comb begin
    int_o    = '0;
    lost_o   = 1'b0;
    ge_one_o = 1'b0;
    big_o    = 1'b0;
    unique case (cls_i)
      CLS_SUB: lost_o = 1'b1;
      CLS_INF: begin ge_one_o = 1'b1; big_o = 1'b1; end
      CLS_NORM: begin
        if (below_one) begin
          lost_o = 1'b1;
        end else if (above_roof) begin
          ge_one_o = 1'b1;
          big_o    = 1'b1;
        end else begin
          ge_one_o = 1'b1;
          int_o    = shifted[INT_W-1:0];
          lost_o   = |(sig_i & ~keep_mask);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dpuw_select.sv
module dpuw_select import dpuw_pkg::*; #(
  parameter int INT_W = 32
) (
  input  logic             sign_i,
  input  cls_e             cls_i,
  input  logic [INT_W-1:0] int_i,
  input  logic             lost_i,
  input  logic             ge_one_i,
  input  logic             big_i,
  output logic [INT_W-1:0] word_o,
  output flags_t           flags_o
);
  logic is_nan, inx;

  assign is_nan = (cls_i == CLS_QNAN) || (cls_i == CLS_SNAN);

  always_comb begin
    word_o          = '0;
    inx             = 1'b0;
    flags_o         = '0;
    if (is_nan) begin
      flags_o.invalid = 1'b1;
      flags_o.snan    = (cls_i == CLS_SNAN);
    end else if (sign_i) begin
      if (ge_one_i) flags_o.invalid = 1'b1;
      else          inx = lost_i;
    end else if (big_i) begin
      word_o          = '1;
      flags_o.invalid = 1'b1;
    end else begin
      word_o = int_i;
      inx    = lost_i;
    end
    flags_o.frac_inx = inx;
    flags_o.inexact  = inx;
    flags_o.rounded  = 1'b0;
  end
endmodule

// File: rtl/dpuw_conv.sv
module dpuw_conv import dpuw_pkg::*; #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 32,
  parameter int VEC_W = 128
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [EXP_W+MAN_W:0]   src_i,
  output logic                   valid_o,
  output logic [VEC_W-1:0]       result_o,
  output logic                   frac_rounded_o,
  output logic                   frac_inexact_o,
  output logic                   invalid_o,
  output logic                   snan_o,
  output logic                   inexact_o
);
  localparam int NUM_WORDS = VEC_W / INT_W;

  logic             sign;
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W:0]   sig;
  cls_e             cls;
  logic [INT_W-1:0] int_val, word;
  logic             lost, ge_one, big;
  flags_t           flags_d, flags_q;
  logic [VEC_W-1:0] result_d;

  dpuw_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
    .src_i(src_i), .sign_o(sign), .exp_o(exp_f), .sig_o(sig), .cls_o(cls)
  );

  dpuw_trunc #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_trunc (
    .exp_i(exp_f), .sig_i(sig), .cls_i(cls),
    .int_o(int_val), .lost_o(lost), .ge_one_o(ge_one), .big_o(big)
  );

  dpuw_select #(.INT_W(INT_W)) u_sel (
    .sign_i(sign), .cls_i(cls), .int_i(int_val), .lost_i(lost),
    .ge_one_i(ge_one), .big_i(big), .word_o(word), .flags_o(flags_d)
  );

  // word 0 is the most significant lane; the top two lanes carry the value
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_lane
    if (w >= NUM_WORDS - 2) begin : g_val
      assign result_d[w*INT_W +: INT_W] = word;
    end else begin : g_zero
      assign result_d[w*INT_W +: INT_W] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      flags_q  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= result_d;
        flags_q  <= flags_d;
      end
    end
  end

  assign frac_rounded_o = flags_q.rounded;
  assign frac_inexact_o = flags_q.frac_inx;
  assign invalid_o      = flags_q.invalid;
  assign snan_o         = flags_q.snan;
  assign inexact_o      = flags_q.inexact;
endmodule

// File: rtl/dpuw_conv_chk.sv
module dpuw_conv_chk #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 32,
  parameter int VEC_W = 128
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [EXP_W+MAN_W:0] src_i,
  input logic                 valid_o,
  input logic [VEC_W-1:0]     result_o,
  input logic                 invalid_o,
  input logic                 snan_o,
  input logic                 inexact_o
);
  logic src_nan;
  assign src_nan = (&src_i[EXP_W+MAN_W-1:MAN_W]) && (src_i[MAN_W-1:0] != '0);

  a_r2_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  a_r1_layout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (result_o[VEC_W-1 -: INT_W] == result_o[VEC_W-INT_W-1 -: INT_W])
                && (result_o[VEC_W-2*INT_W-1:0] == '0));
  a_r3_nan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && src_nan) |=> (invalid_o && !inexact_o && result_o == '0));
  a_r3_snan_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snan_o |-> invalid_o);
  a_r4_negative_zero_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && src_i[EXP_W+MAN_W] && !src_nan) |=> (result_o == '0));
  a_r10_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(invalid_o && inexact_o));
endmodule

bind dpuw_conv dpuw_conv_chk #(
  .EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W), .VEC_W(VEC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .src_i(src_i),
  .valid_o(valid_o), .result_o(result_o), .invalid_o(invalid_o),
  .snan_o(snan_o), .inexact_o(inexact_o)
);

// File: tb/dpuw_conv_test.sv
module dpuw_conv_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [63:0]  src_i = '0;
  logic         valid_o;
  logic [127:0] result_o;
  logic         frac_rounded_o, frac_inexact_o, invalid_o, snan_o, inexact_o;

  int errors = 0;
  int checks = 0;

  always #5 clk_i = ~clk_i;

  dpuw_conv uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .src_i(src_i),
    .valid_o(valid_o), .result_o(result_o), .frac_rounded_o(frac_rounded_o),
    .frac_inexact_o(frac_inexact_o), .invalid_o(invalid_o), .snan_o(snan_o),
    .inexact_o(inexact_o)
  );

  // bundle: {valid, rounded, frac_inx, invalid, snan, inexact}
  task automatic check_out(input string req, input logic [127:0] exp_res,
                           input logic [5:0] exp_fl);
    logic [5:0] got_fl;
    got_fl = {valid_o, frac_rounded_o, frac_inexact_o, invalid_o, snan_o, inexact_o};
    checks++;
    if (result_o !== exp_res || got_fl !== exp_fl) begin
      errors++;
      $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
               req, result_o, got_fl, exp_res, exp_fl);
    end
  endtask

  // drive one operand, sample a half period after the capturing edge
  task automatic convert(input string req, input logic [63:0] src,
                         input logic [31:0] word, input logic fi,
                         input logic inv, input logic sn);
    @(negedge clk_i);
    src_i   = src;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check_out(req, {word, word, 64'h0}, {1'b1, 1'b0, fi, inv, sn, fi});
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    check_out("R2 reset", 128'h0, 6'b0);
  endtask

  task automatic t_nan;
    convert("R3 qnan", 64'h7FF8_0000_0000_0000, 32'h0, 1'b0, 1'b1, 1'b0);
    convert("R3 neg qnan", 64'hFFF8_0000_0000_0001, 32'h0, 1'b0, 1'b1, 1'b0);
    convert("R3 snan", 64'h7FF0_0000_0000_0001, 32'h0, 1'b0, 1'b1, 1'b1);
    convert("R3 snan upper", 64'h7FF4_0000_0000_0000, 32'h0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_neg;
    convert("R4 -1.0", 64'hBFF0_0000_0000_0000, 32'h0, 1'b0, 1'b1, 1'b0);
    convert("R4 -inf", 64'hFFF0_0000_0000_0000, 32'h0, 1'b0, 1'b1, 1'b0);
    convert("R4 -1e300", 64'hFE00_0000_0000_0000, 32'h0, 1'b0, 1'b1, 1'b0);
    convert("R5 -0.5", 64'hBFE0_0000_0000_0000, 32'h0, 1'b1, 1'b0, 1'b0);
    convert("R5 -0.99", 64'hBFEF_FFFF_FFFF_FFFF, 32'h0, 1'b1, 1'b0, 1'b0);
    convert("R5 -subnormal", 64'h8000_0000_0000_0001, 32'h0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_zero;
    convert("R6 +0", 64'h0, 32'h0, 1'b0, 1'b0, 1'b0);
    convert("R6 -0", 64'h8000_0000_0000_0000, 32'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_frac;
    convert("R7 2.5", 64'h4004_0000_0000_0000, 32'd2, 1'b1, 1'b0, 1'b0);
    convert("R7 1000.75", 64'h408F_4600_0000_0000, 32'd1000, 1'b1, 1'b0, 1'b0);
    convert("R7 0.99", 64'h3FEF_FFFF_FFFF_FFFF, 32'd0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_exact;
    convert("R8 1.0", 64'h3FF0_0000_0000_0000, 32'd1, 1'b0, 1'b0, 1'b0);
    convert("R8 3.0", 64'h4008_0000_0000_0000, 32'd3, 1'b0, 1'b0, 1'b0);
    convert("R8 2^31", 64'h41E0_0000_0000_0000, 32'h8000_0000, 1'b0, 1'b0, 1'b0);
    convert("R8 max", 64'h41EF_FFFF_FFE0_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_top;
    convert("R9 max+0.5", 64'h41EF_FFFF_FFF0_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0);
    convert("R10 2^32", 64'h41F0_0000_0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0);
    convert("R10 +inf", 64'h7FF0_0000_0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0);
    convert("R10 huge", 64'h7FE0_0000_0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_sub;
    convert("R12 +subnormal", 64'h0000_0000_0000_0001, 32'h0, 1'b1, 1'b0, 1'b0);
    convert("R12 +big subnormal", 64'h000F_FFFF_FFFF_FFFF, 32'h0, 1'b1, 1'b0, 1'b0);
  endtask

  // R11 is also covered by every convert call (rounded expected 0)
  task automatic t_hold;
    convert("R1 R11 7.25", 64'h401D_0000_0000_0000, 32'd7, 1'b1, 1'b0, 1'b0);
    src_i = 64'h7FF0_0000_0000_0000;
    @(negedge clk_i);
    check_out("R2 hold", {32'd7, 32'd7, 64'h0}, 6'b001001);
  endtask

  initial begin
    t_reset();
    @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_nan();
    t_neg();
    t_zero();
    t_frac();
    t_exact();
    t_top();
    t_sub();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule